// File: doc/BRIEF.md
# Byte-Lane Register Access Adapter

This block connects a little-endian I/O port that issues 1-, 2- or 4-byte accesses at any byte address to a register space built only from 32-bit words. It splits the port address space into three windows: a 16-word bank of SCSI core registers, an 8-word bank of DMA engine registers, and one bus-and-control word. Each window is served by a downstream target that sees only a word index, a word read strobe with same-cycle read data, and a word write strobe with write data.

Any narrow or unaligned write is widened into a read-modify-write of the addressed word. The adapter fetches the current word, replaces only the addressed bytes, and writes the whole word back. A full aligned word write skips the fetch. Reads fetch the word and return only the requested bytes, shifted down to bit 0. Accesses that run past the end of a word, and illegal sizes, are refused with an error response and touch no target. Addresses outside every window read as zero and drop writes.

Top module: `byte_lane_adapter`

## Requirements
- R1: A byte address from 0x00 to 0x3F selects the core window, with word index equal to the address shifted right by 2.
- R2: A byte address from 0x40 to 0x5F selects the DMA window, with word index equal to (address minus 0x40) shifted right by 2.
- R3: Byte addresses 0x70 to 0x73 select the single control word, whose index is 0.
- R4: Every other address (0x60 to 0x6F, 0x74 to 0xFF) is a hole: a read returns 0, a write changes no target, no strobe is issued, and the response error flag is 0.
- R5: A write of size 1, 2 or 3, or at a non-zero byte offset, issues one read strobe and then one write strobe to the same word. The written word holds the low `size` bytes of the write data placed at byte offset `address & 3`, and keeps every other byte of the fetched word.
- R6: A 4-byte write at offset 0 issues no read strobe and writes the write data unchanged as the whole word.
- R7: Read data equals the fetched word shifted right by 8 × (address & 3), with every bit at or above 8 × size cleared. Byte 0 is the least significant byte.
- R8: When size is 0, size is above 4, or (address & 3) + size exceeds 4, the response carries error = 1 and read data 0, and no strobe is issued.
- R9: A request is taken on a clock edge where `req_valid` is high and `req_busy` is low. `req_busy` is high from the next cycle until the response. `rsp_valid` is a one-cycle pulse, two cycles after the accept edge for a read and three cycles after it for a write.
- R10: At most one target strobe is active in any cycle, and a write strobe only ever follows a cycle in the fetch phase.
- R11: During and right after reset, `req_busy` and `rsp_valid` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Access request |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 8 | Byte address |
| req_size | input | 3 | Access size in bytes (1 to 4 legal) |
| req_wdata | input | 32 | Write data, right-aligned in the low bytes |
| req_busy | output | 1 | Access in progress; new requests are not taken |
| rsp_valid | output | 1 | One-cycle response pulse |
| rsp_err | output | 1 | Access refused (boundary crossing or bad size) |
| rsp_rdata | output | 32 | Read data, right-aligned; 0 for writes |
| tgt_idx | output | 4 | Word index within the selected window |
| tgt_wdata | output | 32 | Merged word for a write strobe |
| core_rd | output | 1 | Core window word read strobe |
| core_wr | output | 1 | Core window word write strobe |
| core_rdata | input | 32 | Core word at `tgt_idx`, same cycle |
| dma_rd | output | 1 | DMA window word read strobe |
| dma_wr | output | 1 | DMA window word write strobe |
| dma_rdata | input | 32 | DMA word at `tgt_idx`, same cycle |
| ctl_rd | output | 1 | Control word read strobe |
| ctl_wr | output | 1 | Control word write strobe |
| ctl_rdata | input | 32 | Control word, same cycle |

## Verification
A mis-registered byte offset or size shows up at the next response as wrongly shifted or masked read data. For a write, it shows up as corrupted neighbour bytes in the target word, which is visible as soon as that word is read back. A window or index register holding a stale value sends strobes to the wrong word, and a stuck phase register changes the response latency. The bench therefore compares every response and every touched target word against its own shadow copy right after each access, and it also checks the exact response cycle and the count of read and write strobes.

// File: rtl/bla_pkg.sv
package bla_pkg;

   typedef enum logic [1:0] {
      WIN_NONE = 2'd0,
      WIN_CORE = 2'd1,
      WIN_DMA  = 2'd2,
      WIN_CTL  = 2'd3
   } win_e;

   typedef enum logic [1:0] {
      ST_IDLE  = 2'd0,
      ST_FETCH = 2'd1,
      ST_STORE = 2'd2
   } phase_e;

endpackage

// File: rtl/bla_decode.sv
module bla_decode
   import bla_pkg::*;
#(
   parameter int ADDR_W     = 8,
   parameter int BYTES      = 4,
   parameter int IDX_W      = 4,
   parameter int CORE_BASE  = 0,
   parameter int CORE_WORDS = 16,
   parameter int DMA_BASE   = 64,
   parameter int DMA_WORDS  = 8,
   parameter bit CTL_EN     = 1'b1,
   parameter int CTL_ADDR   = 112,
   localparam int OFF_W     = $clog2(BYTES),
   localparam int SIZE_W    = $clog2(BYTES) + 1
) (
   input  logic [ADDR_W-1:0] addr,
   input  logic [SIZE_W-1:0] size,
   output win_e              win,
   output logic [IDX_W-1:0]  idx,
   output logic [OFF_W-1:0]  off,
   output logic              err,
   output logic              full
);

   localparam int CORE_SPAN = CORE_WORDS * BYTES;
   localparam int DMA_SPAN  = DMA_WORDS * BYTES;
   localparam int CTL_WORD  = CTL_ADDR / BYTES;

   if ((CORE_BASE % BYTES) != 0 || (DMA_BASE % BYTES) != 0) begin : g_bad_align
      $error("window bases must be word aligned");
   end
   if (CORE_SPAN >= (1 << ADDR_W) || DMA_SPAN >= (1 << ADDR_W)) begin : g_bad_span
      $error("window span exceeds address range");
   end
   if ((1 << IDX_W) < CORE_WORDS || (1 << IDX_W) < DMA_WORDS) begin : g_bad_idx
      $error("index width too small for window depth");
   end

   logic [ADDR_W-1:0] core_rel;
   logic [ADDR_W-1:0] dma_rel;
   logic              ctl_hit;

   assign core_rel = addr - ADDR_W'(CORE_BASE);
   assign dma_rel  = addr - ADDR_W'(DMA_BASE);
   assign off      = addr[OFF_W-1:0];

   if (CTL_EN) begin : g_ctl
      assign ctl_hit = (int'(addr[ADDR_W-1:OFF_W]) == CTL_WORD);
   end else begin : g_no_ctl
      assign ctl_hit = 1'b0;
   end

   always_comb begin
      win = WIN_NONE;
      idx = '0;
      if (core_rel < ADDR_W'(CORE_SPAN)) begin
         win = WIN_CORE;
         idx = IDX_W'(core_rel >> OFF_W);
      end else if (dma_rel < ADDR_W'(DMA_SPAN)) begin
         win = WIN_DMA;
         idx = IDX_W'(dma_rel >> OFF_W);
      end else if (ctl_hit) begin
         win = WIN_CTL;
      end
   end

   assign err  = (size == '0) || (int'(size) > BYTES) || (int'(off) + int'(size) > BYTES);
   assign full = (int'(size) == BYTES) && (off == '0);

endmodule

// File: rtl/bla_lanes.sv
module bla_lanes #(
   parameter int DATA_W  = 32,
   localparam int BYTES  = DATA_W / 8,
   localparam int OFF_W  = $clog2(BYTES),
   localparam int SIZE_W = $clog2(BYTES) + 1
) (
   input  logic [DATA_W-1:0] base_word,
   input  logic [DATA_W-1:0] new_data,
   input  logic [DATA_W-1:0] rd_word,
   input  logic [OFF_W-1:0]  off,
   input  logic [SIZE_W-1:0] size,
   output logic [DATA_W-1:0] merged,
   output logic [DATA_W-1:0] extracted
);

   logic [DATA_W-1:0] placed;
   logic [DATA_W-1:0] lowered;

   assign placed  = new_data << {off, 3'b000};
   assign lowered = rd_word  >> {off, 3'b000};

   for (genvar b = 0; b < BYTES; b++) begin : g_lane
      logic in_write;
      logic in_read;
      assign in_write = (b >= int'(off)) && (b < int'(off) + int'(size));
      assign in_read  = (b < int'(size));
      assign merged[8*b +: 8]    = in_write ? placed[8*b +: 8] : base_word[8*b +: 8];
      assign extracted[8*b +: 8] = in_read ? lowered[8*b +: 8] : 8'h00;
   end

endmodule

// File: rtl/bla_ctrl.sv
module bla_ctrl
   import bla_pkg::*;
#(
   parameter int DATA_W  = 32,
   parameter int IDX_W   = 4,
   localparam int BYTES  = DATA_W / 8,
   localparam int OFF_W  = $clog2(BYTES),
   localparam int SIZE_W = $clog2(BYTES) + 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              req_valid,
   input  logic              req_write,
   input  logic [DATA_W-1:0] req_wdata,
   input  win_e              dec_win,
   input  logic [IDX_W-1:0]  dec_idx,
   input  logic [OFF_W-1:0]  dec_off,
   input  logic [SIZE_W-1:0] dec_size,
   input  logic              dec_err,
   input  logic              dec_full,
   input  logic [DATA_W-1:0] sel_word,
   input  logic [DATA_W-1:0] ext_word,
   output win_e              win_q,
   output logic [IDX_W-1:0]  idx_q,
   output logic [OFF_W-1:0]  off_q,
   output logic [SIZE_W-1:0] size_q,
   output logic [DATA_W-1:0] wdata_q,
   output logic [DATA_W-1:0] cur_q,
   output logic              fetch_en,
   output logic              store_en,
   output logic              busy,
   output logic              rsp_valid,
   output logic              rsp_err,
   output logic [DATA_W-1:0] rsp_rdata
);

   phase_e st;
   logic   wr_q;
   logic   err_q;
   logic   full_q;

   assign busy     = (st != ST_IDLE);
   assign fetch_en = (st == ST_FETCH) && !err_q && (win_q != WIN_NONE) && !(wr_q && full_q);
   assign store_en = (st == ST_STORE) && !err_q && (win_q != WIN_NONE);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         st        <= ST_IDLE;
         wr_q      <= 1'b0;
         err_q     <= 1'b0;
         full_q    <= 1'b0;
         win_q     <= WIN_NONE;
         idx_q     <= '0;
         off_q     <= '0;
         size_q    <= '0;
         wdata_q   <= '0;
         cur_q     <= '0;
         rsp_valid <= 1'b0;
         rsp_err   <= 1'b0;
         rsp_rdata <= '0;
      end else begin
         rsp_valid <= 1'b0;
         unique case (st)
            ST_IDLE: begin
               if (req_valid) begin
                  wr_q    <= req_write;
                  err_q   <= dec_err;
                  full_q  <= dec_full;
                  win_q   <= dec_win;
                  idx_q   <= dec_idx;
                  off_q   <= dec_off;
                  size_q  <= dec_size;
                  wdata_q <= req_wdata;
                  st      <= ST_FETCH;
               end
            end
            ST_FETCH: begin
               cur_q     <= fetch_en ? sel_word : '0;
               rsp_rdata <= (fetch_en && !wr_q) ? ext_word : '0;
               if (wr_q) begin
                  st <= ST_STORE;
               end else begin
                  st        <= ST_IDLE;
                  rsp_valid <= 1'b1;
                  rsp_err   <= err_q;
               end
            end
            ST_STORE: begin
               st        <= ST_IDLE;
               rsp_valid <= 1'b1;
               rsp_err   <= err_q;
            end
            default: st <= ST_IDLE;
         endcase
      end
   end

   p_single_pulse_r9: assert property (@(posedge clk) disable iff (!rst_n)
      rsp_valid |=> !rsp_valid);

   p_accept_busy_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && !busy) |=> busy);

   p_rsp_after_busy_r9: assert property (@(posedge clk) disable iff (!rst_n)
      rsp_valid |-> $past(busy));

   p_store_after_fetch_r10: assert property (@(posedge clk) disable iff (!rst_n)
      store_en |-> $past(st == ST_FETCH));

   p_hole_reads_zero_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (rsp_valid && win_q == WIN_NONE) |-> (rsp_rdata == '0));

endmodule

// File: rtl/byte_lane_adapter.sv
module byte_lane_adapter
   import bla_pkg::*;
#(
   parameter int ADDR_W     = 8,
   parameter int DATA_W     = 32,
   parameter int CORE_BASE  = 0,
   parameter int CORE_WORDS = 16,
   parameter int DMA_BASE   = 64,
   parameter int DMA_WORDS  = 8,
   parameter bit CTL_EN     = 1'b1,
   parameter int CTL_ADDR   = 112,
   localparam int BYTES     = DATA_W / 8,
   localparam int SIZE_W    = $clog2(BYTES) + 1,
   localparam int IDX_W     = $clog2((CORE_WORDS > DMA_WORDS) ? CORE_WORDS : DMA_WORDS)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              req_valid,
   input  logic              req_write,
   input  logic [ADDR_W-1:0] req_addr,
   input  logic [SIZE_W-1:0] req_size,
   input  logic [DATA_W-1:0] req_wdata,
   output logic              req_busy,
   output logic              rsp_valid,
   output logic              rsp_err,
   output logic [DATA_W-1:0] rsp_rdata,
   output logic [IDX_W-1:0]  tgt_idx,
   output logic [DATA_W-1:0] tgt_wdata,
   output logic              core_rd,
   output logic              core_wr,
   input  logic [DATA_W-1:0] core_rdata,
   output logic              dma_rd,
   output logic              dma_wr,
   input  logic [DATA_W-1:0] dma_rdata,
   output logic              ctl_rd,
   output logic              ctl_wr,
   input  logic [DATA_W-1:0] ctl_rdata
);

   localparam int OFF_W  = $clog2(BYTES);
   localparam int N_WIN  = 4;

   if (DATA_W % 8 != 0 || BYTES < 2) begin : g_bad_width
      $error("data width must be a multiple of 8 and at least 16");
   end

   win_e              dec_win;
   logic [IDX_W-1:0]  dec_idx;
   logic [OFF_W-1:0]  dec_off;
   logic              dec_err;
   logic              dec_full;
   win_e              win_q;
   logic [OFF_W-1:0]  off_q;
   logic [SIZE_W-1:0] size_q;
   logic [DATA_W-1:0] wdata_q;
   logic [DATA_W-1:0] cur_q;
   logic [DATA_W-1:0] sel_word;
   logic [DATA_W-1:0] ext_word;
   logic              fetch_en;
   logic              store_en;
   logic [N_WIN-1:0]  rd_vec;
   logic [N_WIN-1:0]  wr_vec;

   bla_decode #(
      .ADDR_W     (ADDR_W),
      .BYTES      (BYTES),
      .IDX_W      (IDX_W),
      .CORE_BASE  (CORE_BASE),
      .CORE_WORDS (CORE_WORDS),
      .DMA_BASE   (DMA_BASE),
      .DMA_WORDS  (DMA_WORDS),
      .CTL_EN     (CTL_EN),
      .CTL_ADDR   (CTL_ADDR)
   ) u_decode (
      .addr (req_addr),
      .size (req_size),
      .win  (dec_win),
      .idx  (dec_idx),
      .off  (dec_off),
      .err  (dec_err),
      .full (dec_full)
   );

   bla_ctrl #(
      .DATA_W (DATA_W),
      .IDX_W  (IDX_W)
   ) u_ctrl (
      .clk       (clk),
      .rst_n     (rst_n),
      .req_valid (req_valid),
      .req_write (req_write),
      .req_wdata (req_wdata),
      .dec_win   (dec_win),
      .dec_idx   (dec_idx),
      .dec_off   (dec_off),
      .dec_size  (req_size),
      .dec_err   (dec_err),
      .dec_full  (dec_full),
      .sel_word  (sel_word),
      .ext_word  (ext_word),
      .win_q     (win_q),
      .idx_q     (tgt_idx),
      .off_q     (off_q),
      .size_q    (size_q),
      .wdata_q   (wdata_q),
      .cur_q     (cur_q),
      .fetch_en  (fetch_en),
      .store_en  (store_en),
      .busy      (req_busy),
      .rsp_valid (rsp_valid),
      .rsp_err   (rsp_err),
      .rsp_rdata (rsp_rdata)
   );

   always_comb begin
      unique case (win_q)
         WIN_CORE: sel_word = core_rdata;
         WIN_DMA:  sel_word = dma_rdata;
         WIN_CTL:  sel_word = ctl_rdata;
         default:  sel_word = '0;
      endcase
   end

   bla_lanes #(
      .DATA_W (DATA_W)
   ) u_lanes (
      .base_word (cur_q),
      .new_data  (wdata_q),
      .rd_word   (sel_word),
      .off       (off_q),
      .size      (size_q),
      .merged    (tgt_wdata),
      .extracted (ext_word)
   );

   assign rd_vec[0] = 1'b0;
   assign wr_vec[0] = 1'b0;
   for (genvar w = 1; w < N_WIN; w++) begin : g_strobe
      assign rd_vec[w] = fetch_en && (win_q == win_e'(w));
      assign wr_vec[w] = store_en && (win_q == win_e'(w));
   end

   assign core_rd = rd_vec[WIN_CORE];
   assign core_wr = wr_vec[WIN_CORE];
   assign dma_rd  = rd_vec[WIN_DMA];
   assign dma_wr  = wr_vec[WIN_DMA];
   assign ctl_rd  = rd_vec[WIN_CTL];
   assign ctl_wr  = wr_vec[WIN_CTL];

   p_strobe_onehot_r10: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({core_rd, core_wr, dma_rd, dma_wr, ctl_rd, ctl_wr}));

   p_err_zero_data_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (rsp_valid && rsp_err) |-> (rsp_rdata == '0));

   p_idle_quiet_r11: assert property (@(posedge clk) disable iff (!rst_n)
      !req_busy |-> !(core_rd || core_wr || dma_rd || dma_wr || ctl_rd || ctl_wr));

endmodule

// File: tb/byte_lane_adapter_tb.sv
module byte_lane_adapter_tb;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        req_valid = 1'b0;
   logic        req_write = 1'b0;
   logic [7:0]  req_addr = '0;
   logic [2:0]  req_size = '0;
   logic [31:0] req_wdata = '0;
   logic        req_busy, rsp_valid, rsp_err;
   logic [31:0] rsp_rdata, tgt_wdata;
   logic [3:0]  tgt_idx;
   logic        core_rd, core_wr, dma_rd, dma_wr, ctl_rd, ctl_wr;
   logic [31:0] core_rdata, dma_rdata, ctl_rdata;

   logic [31:0] t_core [16];
   logic [31:0] t_dma  [8];
   logic [31:0] t_ctl;
   logic [31:0] s_core [16];
   logic [31:0] s_dma  [8];
   logic [31:0] s_ctl;

   int n_checks = 0;
   int n_errors = 0;
   int n_rd = 0;
   int n_wr = 0;

   always #5 clk = ~clk;

   byte_lane_adapter u_dut (
      .clk(clk), .rst_n(rst_n),
      .req_valid(req_valid), .req_write(req_write), .req_addr(req_addr),
      .req_size(req_size), .req_wdata(req_wdata),
      .req_busy(req_busy), .rsp_valid(rsp_valid), .rsp_err(rsp_err), .rsp_rdata(rsp_rdata),
      .tgt_idx(tgt_idx), .tgt_wdata(tgt_wdata),
      .core_rd(core_rd), .core_wr(core_wr), .core_rdata(core_rdata),
      .dma_rd(dma_rd), .dma_wr(dma_wr), .dma_rdata(dma_rdata),
      .ctl_rd(ctl_rd), .ctl_wr(ctl_wr), .ctl_rdata(ctl_rdata)
   );

   function automatic logic [31:0] pat(input int w, input int i);
      return 32'h11223344 ^ (w * 32'h0F0F0000) ^ (i * 32'h01030507);
   endfunction

   assign core_rdata = t_core[tgt_idx];
   assign dma_rdata  = t_dma[tgt_idx[2:0]];
   assign ctl_rdata  = t_ctl;

   always @(posedge clk) begin
      if (!rst_n) begin
         for (int i = 0; i < 16; i++) t_core[i] <= pat(1, i);
         for (int i = 0; i < 8; i++)  t_dma[i]  <= pat(2, i);
         t_ctl <= pat(3, 0);
      end else begin
         if (core_wr) t_core[tgt_idx] <= tgt_wdata;
         if (dma_wr)  t_dma[tgt_idx[2:0]] <= tgt_wdata;
         if (ctl_wr)  t_ctl <= tgt_wdata;
      end
      if (rst_n && (core_rd || dma_rd || ctl_rd)) n_rd++;
      if (rst_n && (core_wr || dma_wr || ctl_wr)) n_wr++;
   end

   task automatic check(input bit ok, input string req, input string what,
                        input logic [31:0] act, input logic [31:0] exp);
      n_checks++;
      if (!ok) begin
         n_errors++;
         $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
      end
   endtask

   // window per address: 0 hole, 1 core (R1), 2 dma (R2), 3 control (R3)
   function automatic int win_of(input logic [7:0] a);
      if (a < 8'h40) return 1;
      if (a < 8'h60) return 2;
      if (a[7:2] == 6'h1C) return 3;
      return 0;
   endfunction

   function automatic int idx_of(input logic [7:0] a);
      if (a < 8'h40) return int'(a >> 2);
      if (a < 8'h60) return int'((a - 8'h40) >> 2);
      return 0;
   endfunction

   function automatic logic [31:0] shadow_get(input int w, input int i);
      case (w)
         1: return s_core[i];
         2: return s_dma[i];
         3: return s_ctl;
         default: return 32'h0;
      endcase
   endfunction

   function automatic logic [31:0] target_get(input int w, input int i);
      case (w)
         1: return t_core[i];
         2: return t_dma[i];
         3: return t_ctl;
         default: return 32'h0;
      endcase
   endfunction

   function automatic logic [31:0] size_mask(input int sz);
      return (sz >= 4) ? 32'hFFFF_FFFF : ((32'h1 << (8 * sz)) - 32'h1);
   endfunction

   function automatic logic [31:0] merge_word(input logic [31:0] cur, input logic [31:0] d,
                                              input int off, input int sz);
      logic [31:0] r = cur;
      for (int b = 0; b < 4; b++)
         if (b >= off && b < off + sz) r[8*b +: 8] = d[8*(b-off) +: 8];
      return r;
   endfunction

   task automatic xfer(input bit wr, input logic [7:0] a, input logic [2:0] sz,
                       input logic [31:0] d, input string req);
      int w = win_of(a);
      int ix = idx_of(a);
      int off = int'(a[1:0]);
      int szi = int'(sz);
      bit bad = (szi == 0) || (szi > 4) || (off + szi > 4);
      bit live = !bad && (w != 0);
      logic [31:0] cur = shadow_get(w, ix);
      logic [31:0] exp_data = 32'h0;
      int exp_rd = 0;
      int exp_wr = 0;
      int exp_lat = wr ? 3 : 2;
      int lat;
      int rd0, wr0;
      if (live) begin
         if (wr) begin
            exp_wr = 1;
            exp_rd = (szi == 4 && off == 0) ? 0 : 1;
            case (w)
               1: s_core[ix] = merge_word(cur, d, off, szi);
               2: s_dma[ix]  = merge_word(cur, d, off, szi);
               default: s_ctl = merge_word(cur, d, off, szi);
            endcase
         end else begin
            exp_rd = 1;
            exp_data = (cur >> (8 * off)) & size_mask(szi);
         end
      end
      @(negedge clk);
      rd0 = n_rd; wr0 = n_wr;
      req_valid = 1'b1; req_write = wr; req_addr = a; req_size = sz; req_wdata = d;
      @(negedge clk);
      req_valid = 1'b0;
      check(req_busy === 1'b1, "R9", "busy after accept", {31'b0, req_busy}, 32'h1);
      lat = 1;
      while (rsp_valid !== 1'b1 && lat < 12) begin
         @(negedge clk);
         lat++;
      end
      check(lat == exp_lat, "R9", "response latency", lat, exp_lat);
      check(rsp_err === bad, req, "error flag", {31'b0, rsp_err}, {31'b0, bad});
      check(rsp_rdata === exp_data, req, "read data", rsp_rdata, exp_data);
      check((n_rd - rd0) == exp_rd, req, "read strobes", n_rd - rd0, exp_rd);
      check((n_wr - wr0) == exp_wr, req, "write strobes", n_wr - wr0, exp_wr);
      if (w != 0)
         check(target_get(w, ix) === shadow_get(w, ix), req, "target word",
               target_get(w, ix), shadow_get(w, ix));
      @(negedge clk);
      check(rsp_valid === 1'b0 && req_busy === 1'b0, "R9", "pulse ended",
            {30'b0, rsp_valid, req_busy}, 32'h0);
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      n_checks++;
      n_errors++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
      $finish;
   end

   initial begin
      logic [7:0]  ra;
      logic [2:0]  rs;
      logic [31:0] rd;
      bit          rw;
      string       tag;
      void'($urandom(32'd20240611));
      for (int i = 0; i < 16; i++) s_core[i] = pat(1, i);
      for (int i = 0; i < 8; i++)  s_dma[i]  = pat(2, i);
      s_ctl = pat(3, 0);

      repeat (3) @(negedge clk);
      check(req_busy === 1'b0 && rsp_valid === 1'b0, "R11", "in reset",
            {30'b0, req_busy, rsp_valid}, 32'h0);
      rst_n = 1'b1;
      @(negedge clk);
      check(req_busy === 1'b0 && rsp_valid === 1'b0, "R11", "after reset",
            {30'b0, req_busy, rsp_valid}, 32'h0);

      // directed corners
      xfer(1'b0, 8'h04, 3'd4, 32'h0, "R1");            // core word 1 read
      xfer(1'b1, 8'h01, 3'd1, 32'hFFFF_FFA5, "R5");    // byte write, offset 1
      xfer(1'b0, 8'h00, 3'd4, 32'h0, "R5");            // readback of merged word
      xfer(1'b1, 8'h3E, 3'd2, 32'h0000_BEEF, "R1");    // last core word upper half
      xfer(1'b1, 8'h5C, 3'd4, 32'hCAFE_F00D, "R6");    // last DMA word full write
      xfer(1'b0, 8'h5C, 3'd4, 32'h0, "R2");
      xfer(1'b0, 8'h41, 3'd2, 32'h0, "R7");            // DMA word 0 middle bytes
      xfer(1'b1, 8'h72, 3'd2, 32'h0000_1234, "R3");    // control upper half
      xfer(1'b0, 8'h73, 3'd1, 32'h0, "R3");
      xfer(1'b0, 8'h70, 3'd3, 32'h0, "R7");
      xfer(1'b0, 8'h64, 3'd4, 32'h0, "R4");            // hole read
      xfer(1'b1, 8'h6C, 3'd4, 32'hDEAD_BEEF, "R4");    // hole write
      xfer(1'b1, 8'h74, 3'd1, 32'h0000_0055, "R4");
      xfer(1'b0, 8'hF0, 3'd4, 32'h0, "R4");
      xfer(1'b1, 8'h03, 3'd2, 32'h0000_7777, "R8");    // crosses word boundary
      xfer(1'b0, 8'h42, 3'd4, 32'h0, "R8");
      xfer(1'b1, 8'h10, 3'd0, 32'h0000_0011, "R8");    // size zero
      xfer(1'b0, 8'h10, 3'd5, 32'h0, "R8");            // size five
      xfer(1'b1, 8'h21, 3'd3, 32'h00AB_CDEF, "R5");    // three bytes at offset 1
      xfer(1'b0, 8'h20, 3'd4, 32'h0, "R10");

      // constrained random mix
      for (int n = 0; n < 400; n++) begin
         ra = (($urandom % 16) == 0) ? 8'($urandom % 256) : 8'($urandom % 128);
         rs = (($urandom % 8) == 0) ? 3'($urandom % 8) : 3'(1 + $urandom % 4);
         rd = $urandom;
         rw = 1'($urandom % 2);
         if (rs == 3'd0 || rs > 3'd4 || int'(ra[1:0]) + int'(rs) > 4) tag = "R8";
         else if (win_of(ra) == 0) tag = "R4";
         else if (!rw) tag = "R7";
         else if (rs == 3'd4) tag = "R6";
         else tag = "R5";
         xfer(rw, ra, rs, rd, tag);
      end

      $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
      $finish;
   end

endmodule